// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises an interrupt request after a delay that the processor programs, either once or over and over at a fixed interval. It counts tenths-of-seconds tick enables that the clock core supplies, so every delay is a whole number of tenths. The processor reaches the block's 4-bit register through an address that it shares with a clock-setting register. A bank-select bit, driven from the control register, decides which of the two registers the bus sees. Decoding the address belongs to the calendar block. This block receives a write strobe that is already decoded for that address, plus the bank-select level.

Once armed, the timer keeps counting and keeps raising its request while the clock-setting register is mapped onto the bus. The request is a level that stays high until the processor clears it.

Top module: `pit_timer`

## Requirements
- R1: After reset `irq` is 0, `rdData` is 0 and the timer is idle.
- R2: A write (`regWr` high while `bankSel` is 1) stores `wrData`, and the stored value appears on `rdData` from the next cycle. `wrData[2:0]` is the delay code and `wrData[3]` is the mode bit: 0 means one-shot, 1 means repeat.
- R3: A write strobe while `bankSel` is 0 is ignored. `rdData`, the delay code, the mode and the running count all stay as they were.
- R4: In ticks, delay codes 1 to 7 give 1, 5, 10, 50, 100, 300 and 600. `irq` is high from the cycle after the clock edge that samples the last tick of the delay.
- R5: Delay code 0 stops the timer, and no `irq` is ever raised while it is loaded.
- R6: In one-shot mode the timer raises `irq` once and then stops counting.
- R7: In repeat mode the timer restarts its count at each expiry and raises `irq` again after every full delay.
- R8: `irq` stays high until `intClr` is pulsed. An expiry while `irq` is already high leaves it high. An expiry in the same cycle as `intClr` wins, and `irq` stays high.
- R9: Every accepted write restarts the delay from zero, even if it writes the same value.
- R10: The count advances only on cycles where `tickEn` is high, whatever the level of `bankSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle enable for each tenth of a second |
| bankSel | input | 1 | 1 maps this register onto the shared address |
| regWr | input | 1 | Decoded write strobe for the shared address |
| wrData | input | 4 | Write data: [2:0] delay code, [3] repeat mode |
| intClr | input | 1 | One-cycle clear of the interrupt request |
| rdData | output | 4 | Stored register value |
| irq | output | 1 | Interrupt request, active high, sticky |

## Verification
The bench walks every delay code to its exact tick count. A table entry that is off by one tick, or a count that begins at one instead of zero, moves the expiry by a cycle and gets caught. It runs both modes past their first expiry. A one-shot timer that reloads would interrupt a second time, and a repeat timer that stops would go silent.

It also lines up a clear with an expiry in the same cycle, where a design that lets the clear win loses an interrupt. It writes with the bank deselected part way through a count, where a leaky bank gate either changes the delay or restarts it. Finally, it rewrites the register with an unchanged value, which must still restart the delay.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture wrData, clear count
    logic clrCnt;  // restart count at expiry
    logic incCnt;  // advance count on a tick
    logic setIrq;  // delay elapsed
  } pitStrobe_t;

  // Delay length in ticks for a 3-bit code; tps = ticks per second
  function automatic int unsigned delayTicks(input logic [2:0] code,
                                             input int unsigned tps);
    case (code)
      3'd1:    delayTicks = 1;
      3'd2:    delayTicks = tps / 2;
      3'd3:    delayTicks = tps;
      3'd4:    delayTicks = 5 * tps;
      3'd5:    delayTicks = 10 * tps;
      3'd6:    delayTicks = 30 * tps;
      3'd7:    delayTicks = 60 * tps;
      default: delayTicks = 0;
    endcase
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       bankSel,
  input  logic       regWr,
  input  logic [2:0] wrCode,
  input  logic       modeRep,
  input  logic       atLast,
  output pitStrobe_t stb
);

  logic running, runNext;
  logic wrHit;

  assign wrHit = regWr & bankSel;

  always_comb begin
    stb     = '0;
    runNext = running;
    if (wrHit) begin
      stb.load = 1'b1;
      runNext  = (wrCode != 3'd0);
    end else if (tickEn && running) begin
      if (atLast) begin
        stb.setIrq = 1'b1;
        stb.clrCnt = 1'b1;
        if (!modeRep) runNext = 1'b0;
      end else begin
        stb.incCnt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else       running <= runNext;
  end

endmodule

// File: rtl/pit_dp.sv
module pit_dp
  import pit_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  pitStrobe_t stb,
  input  logic [3:0] wrData,
  input  logic       intClr,
  output logic       atLast,
  output logic       modeRep,
  output logic [3:0] rdData,
  output logic       irq
);

  localparam int unsigned MAX_TICKS = 60 * TICKS_PER_SEC;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic [3:0]       regVal;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastVal;

  assign lastVal = CNT_W'(delayTicks(regVal[2:0], TICKS_PER_SEC) - 1);
  assign atLast  = (count == lastVal);
  assign modeRep = regVal[3];
  assign rdData  = regVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regVal <= '0;
      count  <= '0;
    end else if (stb.load) begin
      regVal <= wrData;
      count  <= '0;
    end else if (stb.clrCnt) begin
      count  <= '0;
    end else if (stb.incCnt) begin
      count  <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irq <= 1'b0;
    else if (stb.setIrq) irq <= 1'b1;
    else if (intClr)     irq <= 1'b0;
  end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       bankSel,
  input  logic       regWr,
  input  logic [3:0] wrData,
  input  logic       intClr,
  output logic [3:0] rdData,
  output logic       irq
);

  pitStrobe_t stb;
  logic       atLast;
  logic       modeRep;

  pit_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .bankSel (bankSel),
    .regWr   (regWr),
    .wrCode  (wrData[2:0]),
    .modeRep (modeRep),
    .atLast  (atLast),
    .stb     (stb)
  );

  pit_dp #(.TICKS_PER_SEC(TICKS_PER_SEC)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .intClr  (intClr),
    .atLast  (atLast),
    .modeRep (modeRep),
    .rdData  (rdData),
    .irq     (irq)
  );

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       bankSel,
  input logic       regWr,
  input logic [3:0] wrData,
  input logic       intClr,
  input logic [3:0] rdData,
  input logic       irq
);

  // R2: accepted write is visible next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && bankSel) |=> (rdData == $past(wrData)));

  // R3: write with bank deselected leaves the register alone
  p_bank_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !bankSel) |=> $stable(rdData));

  // R5: no request can rise while code 0 was loaded
  p_off_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(rdData[2:0]) != 3'd0));

  // R10: the request only rises after a tick
  p_rise_on_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(tickEn));

  // R8: sticky until cleared
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !intClr) |=> irq);

  // R8: a clear with no tick drops the request
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && !tickEn) |=> !irq);

endmodule

bind pit_timer pit_timer_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .bankSel (bankSel),
  .regWr   (regWr),
  .wrData  (wrData),
  .intClr  (intClr),
  .rdData  (rdData),
  .irq     (irq)
);

// File: tb/pit_timer_tb_top.sv
module pit_timer_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       bankSel = 1'b1;
  logic       regWr = 1'b0;
  logic [3:0] wrData = '0;
  logic       intClr = 1'b0;
  logic [3:0] rdData;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pit_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .bankSel(bankSel),
    .regWr(regWr), .wrData(wrData), .intClr(intClr),
    .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs change and outputs are sampled at the falling edge
  task automatic writeReg(input logic [3:0] v, input logic sel);
    @(negedge clk);
    regWr = 1'b1; wrData = v; bankSel = sel;
    @(negedge clk);
    regWr = 1'b0; bankSel = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
    end
    @(negedge clk); tickEn = 1'b0;
  endtask

  task automatic clearIrq();
    @(negedge clk); intClr = 1'b1;
    @(negedge clk); intClr = 1'b0;
  endtask

  function automatic int expTicks(input int code);
    case (code)
      1: return 1;   2: return 5;   3: return 10;  4: return 50;
      5: return 100; 6: return 300; 7: return 600;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 rdData", rdData, 0);
  endtask

  task automatic t_delays();
    for (int c = 1; c < 8; c++) begin
      writeReg(4'(c), 1'b1);
      clearIrq();
      chk("R2 readback", rdData, c);
      if (expTicks(c) > 1) begin
        ticks(expTicks(c) - 1);
        chk($sformatf("R4 code %0d early", c), irq, 0);
      end
      ticks(1);
      chk($sformatf("R4 code %0d expiry", c), irq, 1);
    end
  endtask

  task automatic t_oneShot();
    writeReg(4'h2, 1'b1); clearIrq();
    ticks(5);
    chk("R6 first expiry", irq, 1);
    clearIrq();
    ticks(12);
    chk("R6 stays quiet", irq, 0);
  endtask

  task automatic t_repeat();
    writeReg(4'hA, 1'b1); clearIrq();
    ticks(5);
    chk("R7 first expiry", irq, 1);
    clearIrq();
    ticks(4);
    chk("R7 before second", irq, 0);
    ticks(1);
    chk("R7 second expiry", irq, 1);
  endtask

  task automatic t_sticky();
    writeReg(4'h9, 1'b1); clearIrq();
    ticks(1);
    chk("R8 set", irq, 1);
    ticks(3);
    chk("R8 re-expiry keeps set", irq, 1);
    repeat (4) @(negedge clk);
    chk("R8 holds without clear", irq, 1);
    @(negedge clk); intClr = 1'b1; tickEn = 1'b1;
    @(negedge clk); intClr = 1'b0; tickEn = 1'b0;
    chk("R8 expiry beats clear", irq, 1);
    clearIrq();
    chk("R8 clear", irq, 0);
  endtask

  task automatic t_off();
    writeReg(4'h8, 1'b1); clearIrq();
    ticks(700);
    chk("R5 code 0 silent", irq, 0);
  endtask

  task automatic t_bank();
    writeReg(4'hA, 1'b1); clearIrq();
    ticks(3);
    writeReg(4'h1, 1'b0);
    chk("R3 rdData unchanged", rdData, 10);
    @(negedge clk); bankSel = 1'b0;
    ticks(1);
    chk("R3 delay unchanged", irq, 0);
    ticks(1);
    chk("R10 counts while hidden", irq, 1);
    bankSel = 1'b1;
  endtask

  task automatic t_restart();
    writeReg(4'h2, 1'b1); clearIrq();
    ticks(3);
    writeReg(4'h2, 1'b1);
    ticks(4);
    chk("R9 restarted", irq, 0);
    ticks(1);
    chk("R9 expiry after restart", irq, 1);
  endtask

  task automatic t_noTick();
    writeReg(4'h1, 1'b1); clearIrq();
    repeat (6) @(negedge clk);
    chk("R10 no tick no count", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_delays();
    t_oneShot();
    t_repeat();
    t_sticky();
    t_off();
    t_bank();
    t_restart();
    t_noTick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule